// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This unit takes a 32-bit IEEE single-precision bit pattern and produces the matching 16-bit half-precision bit pattern. One of four rounding directions is chosen per word: nearest with ties to even, toward zero, toward plus infinity or toward minus infinity. The conversion is combinational and lands in one output register, so a word offered with `in_valid` appears one clock later with `out_valid`.

Every class of input is covered. NaN and infinity are mapped. Magnitudes too large for half precision saturate in a way that depends on the direction and the sign. In-range values are repacked and rounded. Small values become subnormal results. Anything below the smallest subnormal underflows, also depending on the direction and the sign. The source sign is always carried to bit 15 of the result.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_half` is 16'h0000.
- R2: `out_valid` equals `in_valid` of the previous clock. `out_half` takes a new value only in the clock after a word is offered with `in_valid` high, and otherwise holds its value.
- R3: Write the source magnitude as bits 30:0. A magnitude above 31'h7F800000 gives magnitude 15'h7E00. A magnitude equal to 31'h7F800000 gives 15'h7C00. In both cases the source sign goes to bit 15.
- R4: A finite magnitude of at least 143<<23 overflows. Direction `rnd_mode` 00 (nearest-even) gives 7C00. 01 (toward zero) gives 7BFF. 10 (toward plus infinity) gives 7C00 when positive and 7BFF when negative. 11 (toward minus infinity) gives 7C00 when negative and 7BFF when positive. The sign bit is set from the source.
- R5: A magnitude from 113<<23 up to below overflow gives a normal result in direction 01. The result exponent field (bits 14:10) is the source exponent minus 112, and the fraction is source bits 22:13.
- R6: In the normal range, take guard = source bit 12 and sticky = OR of source bits 11:0. Direction 00 adds guard AND (sticky OR result LSB). Direction 10 adds (NOT sign) AND (guard OR sticky). Direction 11 adds sign AND (guard OR sticky). The add is on the packed 15-bit field, so a carry raises the exponent, up to 7C00.
- R7: A magnitude from 102<<23 up to below 113<<23 gives a subnormal result. The 24-bit significand with its hidden bit is shifted right by (126 − exponent), then rounded as in R6, with guard and sticky taken from the bits shifted out. A carry may give the smallest normal, 0400.
- R8: A nonzero magnitude below 102<<23 underflows. It gives magnitude 0001 in direction 10 when positive and in direction 11 when negative, and 0000 otherwise.
- R9: A zero of either sign gives a zero with the same sign in every direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word is present |
| in_word | input | 32 | Single-precision source pattern |
| rnd_mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| out_valid | output | 1 | Result register holds a fresh conversion |
| out_half | output | 16 | Half-precision result pattern |

## Verification
Rounding and range classification can act on the same word. A round-up carry moves a subnormal into the normal range, and it moves the largest finite value to infinity without passing through the overflow path. The bench provokes both with directed words whose retained fraction is all ones, just below the subnormal-to-normal boundary and just below the overflow threshold, in each of the four directions. Random words concentrated near those exponents add more cases. Every result is judged against a reference that rounds one generic integer quotient and clamps afterwards, a different method from the range-by-range structure of the design.

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [15:0] out_half
);

  localparam logic [1:0]  M_NEAR = 2'b00;
  localparam logic [1:0]  M_ZERO = 2'b01;
  localparam logic [1:0]  M_UP   = 2'b10;
  localparam logic [1:0]  M_DOWN = 2'b11;

  localparam logic [30:0] INF_MAG  = 31'h7F80_0000;
  localparam logic [30:0] OVF_MAG  = 31'(143) << 23;
  localparam logic [30:0] NORM_MAG = 31'(113) << 23;
  localparam logic [30:0] SUB_MAG  = 31'(102) << 23;

  localparam logic [14:0] H_INF  = 15'h7C00;
  localparam logic [14:0] H_QNAN = 15'h7E00;
  localparam logic [14:0] H_MAX  = 15'h7BFF;

  logic        sgn;
  logic [30:0] mag;
  logic [7:0]  expo;
  logic [23:0] sig;
  logic [4:0]  sh;
  logic [14:0] nrm_val, sub_val, res;
  logic        nrm_g, nrm_s, sub_g, sub_s;

  assign sgn  = in_word[31];
  assign mag  = in_word[30:0];
  assign expo = mag[30:23];
  assign sig  = {1'b1, mag[22:0]};

  assign nrm_val = {5'(expo - 8'd112), mag[22:13]};
  assign nrm_g   = mag[12];
  assign nrm_s   = |mag[11:0];

  assign sh      = 5'(8'd125 - expo);
  assign sub_val = 15'(sig >> (sh + 5'd1));
  assign sub_g   = sig[sh];
  assign sub_s   = |(sig & ((24'd1 << sh) - 24'd1));

  function automatic logic [14:0] round_up(input logic [14:0] v, input logic g,
                                           input logic s, input logic neg,
                                           input logic [1:0] m);
    logic inc;
    case (m)
      M_NEAR:  inc = g & (s | v[0]);
      M_UP:    inc = ~neg & (g | s);
      M_DOWN:  inc = neg & (g | s);
      default: inc = 1'b0;
    endcase
    return v + 15'(inc);
  endfunction

  always_comb begin
    if (mag > INF_MAG)
      res = H_QNAN;
    else if (mag == INF_MAG)
      res = H_INF;
    else if (mag >= OVF_MAG) begin
      case (rnd_mode)
        M_NEAR:  res = H_INF;
        M_ZERO:  res = H_MAX;
        M_UP:    res = sgn ? H_MAX : H_INF;
        default: res = sgn ? H_INF : H_MAX;
      endcase
    end
    else if (mag >= NORM_MAG)
      res = round_up(nrm_val, nrm_g, nrm_s, sgn, rnd_mode);
    else if (mag >= SUB_MAG)
      res = round_up(sub_val, sub_g, sub_s, sgn, rnd_mode);
    else if (mag != 31'd0)
      res = 15'(((rnd_mode == M_UP) && !sgn) || ((rnd_mode == M_DOWN) && sgn));
    else
      res = 15'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= 16'h0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_half <= {sgn, res};
    end
  end

endmodule

// File: rtl/f32_to_f16_cvt_chk.sv
module f32_to_f16_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic [1:0]  rnd_mode,
  input logic        out_valid,
  input logic [15:0] out_half
);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_half));

  // R3
  nan_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:0] > 31'h7F80_0000) |=> (out_half[14:0] == 15'h7E00));

  // R4
  ovf_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_mode == 2'b01 && in_word[30:0] >= (31'(143) << 23)
     && in_word[30:0] < 31'h7F80_0000) |=> (out_half[14:0] == 15'h7BFF));

  // R9
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[30:0] == 31'd0) |=> (out_half[14:0] == 15'd0));

  // R3
  sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_half[15] == $past(in_word[31])));

endmodule

bind f32_to_f16_cvt f32_to_f16_cvt_chk u_chk (.*);

// File: tb/f32_to_f16_cvt_test.sv
module f32_to_f16_cvt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'd0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        out_valid;
  logic [15:0] out_half;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  f32_to_f16_cvt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .out_half(out_half)
  );

  function automatic logic [15:0] model(input logic [31:0] w, input logic [1:0] m);
    longint ee, sig, sh, q, rem, half, packed_v;
    logic neg, g, st, inc;
    logic [14:0] r;
    neg = w[31];
    ee  = longint'(w[30:23]);
    if (ee == 255) r = (w[22:0] != 0) ? 15'h7E00 : 15'h7C00;
    else if (w[30:0] == 0) r = 15'd0;
    else begin
      sig = (ee == 0) ? longint'(w[22:0]) : (longint'(w[22:0]) | (64'sd1 << 23));
      if (ee == 0) ee = 1;
      sh = (ee >= 113) ? 13 : 126 - ee;
      if (sh > 40) sh = 40;
      q    = sig >> sh;
      rem  = sig & ((64'sd1 << sh) - 1);
      half = 64'sd1 << (sh - 1);
      g    = rem >= half;
      st   = (rem & (half - 1)) != 0;
      packed_v = (ee >= 113) ? (((ee - 112) << 10) + q - 1024) : q;
      case (m)
        2'b00:   inc = g & (st | packed_v[0]);
        2'b10:   inc = !neg & (g | st);
        2'b11:   inc = neg & (g | st);
        default: inc = 1'b0;
      endcase
      packed_v = packed_v + longint'(inc);
      if (packed_v >= 64'h7C00) begin
        case (m)
          2'b00:   r = 15'h7C00;
          2'b01:   r = 15'h7BFF;
          2'b10:   r = neg ? 15'h7BFF : 15'h7C00;
          default: r = neg ? 15'h7C00 : 15'h7BFF;
        endcase
      end else r = 15'(packed_v);
    end
    return {neg, r};
  endfunction

  function automatic string req_of(input logic [31:0] w, input logic [1:0] m);
    logic [30:0] a;
    a = w[30:0];
    if (a >= 31'h7F80_0000) return "R3";
    if (a >= (31'(143) << 23)) return "R4";
    if (a == 0) return "R9";
    if (a < (31'(102) << 23)) return "R8";
    if (a < (31'(113) << 23)) return "R7";
    return (m == 2'b01) ? "R5" : "R6";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic convert(input logic [31:0] w, input logic [1:0] m);
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    rnd_mode = m;
    e = model(w, m);
    @(negedge clk);
    check("R2", "out_valid after word", 32'(out_valid), 32'd1);
    check(req_of(w, m), $sformatf("word %h mode %0d", w, m), 32'(out_half), 32'(e));
  endtask

  task automatic idle(input logic [31:0] w);
    logic [15:0] held;
    @(negedge clk);
    held     = out_half;
    in_valid = 1'b0;
    in_word  = w;
    @(negedge clk);
    check("R2", "out_valid idle", 32'(out_valid), 32'd0);
    check("R2", "out_half held", 32'(out_half), 32'(held));
  endtask

  function automatic logic [31:0] rand_word();
    logic [7:0] e;
    logic [22:0] mt;
    case ($urandom % 6)
      0:       e = 8'($urandom);
      1:       e = 8'(98 + $urandom % 18);
      2:       e = 8'(139 + $urandom % 6);
      3:       e = 8'(110 + $urandom % 6);
      4:       e = ($urandom % 2) ? 8'd255 : 8'd0;
      default: e = 8'(100 + $urandom % 46);
    endcase
    mt = 23'($urandom);
    case ($urandom % 4)
      0: mt = {mt[22:13], 1'b1, 12'd0};
      1: mt = mt | 23'h7FE000;
      default: ;
    endcase
    return {1'($urandom), e, mt};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] dir [16];
    void'($urandom(32'd1234));
    dir = '{32'h7FC0_0000, 32'hFF80_0000, 32'h4780_0000, 32'hC780_0000,
            32'h477F_E000, 32'h477F_F000, 32'hC77F_F001, 32'h3300_0000,
            32'h3300_0001, 32'h387F_F000, 32'hB87F_C001, 32'h3F80_0000,
            32'h0000_0001, 32'h8000_0001, 32'h0000_0000, 32'h8000_0000};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R1", "out_half in reset", 32'(out_half), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++)
      for (int m = 0; m < 4; m++)
        convert(dir[k], 2'(m));
    idle(32'h4000_0000);
    for (int n = 0; n < 3000; n++) begin
      convert(rand_word(), 2'($urandom));
      if ($urandom % 8 == 0) idle(rand_word());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule